// File: doc/BRIEF.md
# RV32I Control Decoder

This block turns the fixed fields of a 32-bit RV32I base-integer instruction into the control word for a single-cycle datapath. It works in two levels. The first level looks only at the 7-bit major opcode. It sets the write-back enables, the operand and result selects, the memory strobes, the jump and branch flags, and a 2-bit operation class. The second level combines that class with funct3 and bit 5 of funct7 to give a 4-bit ALU operation code.

The decoder is purely combinational and has no clock. A datapath feeds it the opcode, funct3 and funct7 bit 5 slices taken straight from the instruction word, and uses the outputs in the same cycle. When a branch is decoded, the ALU code depends on funct3. Equality branches get a subtract, signed branches get a signed compare, and unsigned branches get an unsigned compare. The datapath can therefore read the branch condition from the ALU result. Any opcode the decoder does not recognise produces an all-zero control word.

Top module: `rvdec_ctrl_decoder`

## Requirements
- R1: For any opcode outside the nine listed in R2 to R8, every output is 0, including `alu_class` and `alu_sel`.
- R2: Opcode 0x33 (register-register) sets `reg_wr`=1 and `alu_class`=10. All other single-bit outputs are 0.
- R3: Opcode 0x13 (register-immediate) sets `reg_wr`=1, `opb_imm`=1 and `alu_class`=10. Under funct3=000 it always gives add (0010), whatever `funct7_b5` is.
- R4: Opcode 0x03 (load) sets `reg_wr`, `opb_imm`, `wb_from_mem` and `mem_rd` to 1, with `alu_class`=00 and `alu_sel`=0010 (add).
- R5: Opcode 0x23 (store) sets `opb_imm`=1 and `mem_wr`=1, with `alu_class`=00 and `alu_sel`=0010. `reg_wr` is 0.
- R6: Opcode 0x63 (branch) sets `is_branch`=1 and `alu_class`=01. The value of `alu_sel` depends on funct3:
  - 000 or 001 gives sub (0110).
  - 100 or 101 gives slt (0111).
  - 110 or 111 gives sltu (1000).
  - 010 or 011 gives sub.
- R7: Opcode 0x6F (jal) sets `reg_wr`=1 and `is_jal`=1. Opcode 0x67 (jalr) sets `reg_wr`=1, `opb_imm`=1 and `is_jalr`=1. Both use `alu_class`=00 and add.
- R8: Opcode 0x37 sets `reg_wr`=1 and `wb_upper_imm`=1. Opcode 0x17 sets `reg_wr`=1 and `wb_pc_imm`=1. Both use `alu_class`=00 and add.
- R9: Under `alu_class`=10, funct3 chooses `alu_sel` as follows:
  - 001 gives sll (0100).
  - 010 gives slt (0111).
  - 011 gives sltu (1000).
  - 100 gives xor (0011).
  - 110 gives or (0001).
  - 111 gives and (0000).
- R10: Under `alu_class`=10, funct3=101 gives sra (1101) when `funct7_b5`=1 and srl (0101) otherwise, for both 0x33 and 0x13. Opcode 0x33 with funct3=000 gives sub (0110) when `funct7_b5`=1 and add otherwise.
- R11: At most one of `mem_rd` and `mem_wr` is 1. At most one of `is_branch`, `is_jal` and `is_jalr` is 1. At most one of `wb_from_mem`, `wb_upper_imm` and `wb_pc_imm` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Major opcode, instruction bits 6:0 |
| funct3 | input | 3 | Minor function, instruction bits 14:12 |
| funct7_b5 | input | 1 | Instruction bit 30 (funct7 bit 5) |
| reg_wr | output | 1 | Destination register write enable |
| opb_imm | output | 1 | ALU B operand takes the immediate |
| wb_from_mem | output | 1 | Write-back takes memory read data |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| is_branch | output | 1 | Conditional branch instruction |
| is_jal | output | 1 | PC-relative jump with link |
| is_jalr | output | 1 | Register-indirect jump with link |
| wb_upper_imm | output | 1 | Write-back takes the upper immediate |
| wb_pc_imm | output | 1 | Write-back takes PC plus immediate |
| alu_class | output | 2 | 00 add, 01 compare/subtract, 10 function-decoded |
| alu_sel | output | 4 | ALU operation code |

## Verification
The immediate assertions assume that every input bit is a defined 0 or 1 whenever the decode is evaluated. They also assume that `funct7_b5` is the only part of funct7 that matters. The bench meets both assumptions by driving only whole binary values: it sweeps all 128 opcodes against all eight funct3 values and both `funct7_b5` levels, and it changes inputs only between checks. Because unassigned and reserved opcodes are part of that sweep, the zero-output rule is exercised on every encoding the block must reject.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int OPC_W = 7;
    localparam int F3_W  = 3;
    localparam int CLS_W = 2;
    localparam int SEL_W = 4;

    localparam logic [OPC_W-1:0] OPC_REG    = 7'h33;
    localparam logic [OPC_W-1:0] OPC_IMM    = 7'h13;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'h03;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'h23;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'h37;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'h17;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'h6F;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'h67;

    typedef enum logic [CLS_W-1:0] {
        CLS_ADD   = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FUNCT = 2'b10,
        CLS_NONE  = 2'b11
    } alu_class_e;

    localparam logic [SEL_W-1:0] SEL_AND  = 4'b0000;
    localparam logic [SEL_W-1:0] SEL_OR   = 4'b0001;
    localparam logic [SEL_W-1:0] SEL_ADD  = 4'b0010;
    localparam logic [SEL_W-1:0] SEL_XOR  = 4'b0011;
    localparam logic [SEL_W-1:0] SEL_SLL  = 4'b0100;
    localparam logic [SEL_W-1:0] SEL_SRL  = 4'b0101;
    localparam logic [SEL_W-1:0] SEL_SUB  = 4'b0110;
    localparam logic [SEL_W-1:0] SEL_SLT  = 4'b0111;
    localparam logic [SEL_W-1:0] SEL_SLTU = 4'b1000;
    localparam logic [SEL_W-1:0] SEL_SRA  = 4'b1101;

    typedef struct packed {
        logic       known;
        logic       op_imm;
        logic       reg_wr;
        logic       opb_imm;
        logic       wb_from_mem;
        logic       mem_rd;
        logic       mem_wr;
        logic       is_branch;
        logic       is_jal;
        logic       is_jalr;
        logic       wb_upper_imm;
        logic       wb_pc_imm;
        alu_class_e cls;
    } ctrl_t;

endpackage

// File: rtl/rvdec_main_ctrl.sv
module rvdec_main_ctrl
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctl
);

    always_comb begin
        ctl     = '0;
        ctl.cls = CLS_ADD;
        case (opcode)
            OPC_REG: begin
                ctl.known  = 1'b1;
                ctl.reg_wr = 1'b1;
                ctl.cls    = CLS_FUNCT;
            end
            OPC_IMM: begin
                ctl.known   = 1'b1;
                ctl.op_imm  = 1'b1;
                ctl.reg_wr  = 1'b1;
                ctl.opb_imm = 1'b1;
                ctl.cls     = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctl.known       = 1'b1;
                ctl.reg_wr      = 1'b1;
                ctl.opb_imm     = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.mem_rd      = 1'b1;
            end
            OPC_STORE: begin
                ctl.known   = 1'b1;
                ctl.opb_imm = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OPC_BRANCH: begin
                ctl.known     = 1'b1;
                ctl.is_branch = 1'b1;
                ctl.cls       = CLS_CMP;
            end
            OPC_JAL: begin
                ctl.known  = 1'b1;
                ctl.reg_wr = 1'b1;
                ctl.is_jal = 1'b1;
            end
            OPC_JALR: begin
                ctl.known   = 1'b1;
                ctl.reg_wr  = 1'b1;
                ctl.opb_imm = 1'b1;
                ctl.is_jalr = 1'b1;
            end
            OPC_LUI: begin
                ctl.known        = 1'b1;
                ctl.reg_wr       = 1'b1;
                ctl.wb_upper_imm = 1'b1;
            end
            OPC_AUIPC: begin
                ctl.known     = 1'b1;
                ctl.reg_wr    = 1'b1;
                ctl.wb_pc_imm = 1'b1;
            end
            default: begin
                ctl     = '0;
                ctl.cls = CLS_ADD;
            end
        endcase
    end

    always_comb begin
        // R11
        mem_excl_chk: assert (!(ctl.mem_rd && ctl.mem_wr))
            else $error("memory read and write strobes both set");
        // R11
        flow_excl_chk: assert ($onehot0({ctl.is_branch, ctl.is_jal, ctl.is_jalr}))
            else $error("more than one control-flow flag set");
        // R11
        wb_excl_chk: assert ($onehot0({ctl.wb_from_mem, ctl.wb_upper_imm, ctl.wb_pc_imm}))
            else $error("more than one write-back source set");
        // R4
        load_path_chk: assert (!ctl.mem_rd || (ctl.wb_from_mem && ctl.opb_imm && ctl.reg_wr))
            else $error("load missing its write-back or operand select");
        // R5
        store_nowb_chk: assert (!ctl.mem_wr || !ctl.reg_wr)
            else $error("store enables register write");
    end

endmodule

// File: rtl/rvdec_alu_ctrl.sv
module rvdec_alu_ctrl
    import rvdec_pkg::*;
(
    input  alu_class_e        cls,
    input  logic [F3_W-1:0]   funct3,
    input  logic              funct7_b5,
    input  logic              op_imm,
    output logic [SEL_W-1:0]  sel
);

    logic [SEL_W-1:0] funct_sel;
    logic [SEL_W-1:0] cmp_sel;

    always_comb begin
        case (funct3)
            3'b000:  funct_sel = (funct7_b5 && !op_imm) ? SEL_SUB : SEL_ADD;
            3'b001:  funct_sel = SEL_SLL;
            3'b010:  funct_sel = SEL_SLT;
            3'b011:  funct_sel = SEL_SLTU;
            3'b100:  funct_sel = SEL_XOR;
            3'b101:  funct_sel = funct7_b5 ? SEL_SRA : SEL_SRL;
            3'b110:  funct_sel = SEL_OR;
            default: funct_sel = SEL_AND;
        endcase
    end

    always_comb begin
        case (funct3[2:1])
            2'b10:   cmp_sel = SEL_SLT;
            2'b11:   cmp_sel = SEL_SLTU;
            default: cmp_sel = SEL_SUB;
        endcase
    end

    always_comb begin
        unique case (cls)
            CLS_ADD:   sel = SEL_ADD;
            CLS_CMP:   sel = cmp_sel;
            CLS_FUNCT: sel = funct_sel;
            default:   sel = SEL_AND;
        endcase
    end

    always_comb begin
        // R6
        cmp_code_chk: assert (cls != CLS_CMP || sel == SEL_SUB || sel == SEL_SLT || sel == SEL_SLTU)
            else $error("compare class produced a non-compare code");
        // R3
        imm_nosub_chk: assert (!(cls == CLS_FUNCT && op_imm) || sel != SEL_SUB)
            else $error("immediate arithmetic produced subtract");
    end

endmodule

// File: rtl/rvdec_ctrl_decoder.sv
module rvdec_ctrl_decoder
    import rvdec_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       funct7_b5,
    output logic       reg_wr,
    output logic       opb_imm,
    output logic       wb_from_mem,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       is_branch,
    output logic       is_jal,
    output logic       is_jalr,
    output logic       wb_upper_imm,
    output logic       wb_pc_imm,
    output logic [1:0] alu_class,
    output logic [3:0] alu_sel
);

    ctrl_t            ctl;
    logic [SEL_W-1:0] sel_raw;

    rvdec_main_ctrl u_main (
        .opcode (opcode),
        .ctl    (ctl)
    );

    rvdec_alu_ctrl u_alu (
        .cls       (ctl.cls),
        .funct3    (funct3),
        .funct7_b5 (funct7_b5),
        .op_imm    (ctl.op_imm),
        .sel       (sel_raw)
    );

    assign reg_wr       = ctl.reg_wr;
    assign opb_imm      = ctl.opb_imm;
    assign wb_from_mem  = ctl.wb_from_mem;
    assign mem_rd       = ctl.mem_rd;
    assign mem_wr       = ctl.mem_wr;
    assign is_branch    = ctl.is_branch;
    assign is_jal       = ctl.is_jal;
    assign is_jalr      = ctl.is_jalr;
    assign wb_upper_imm = ctl.wb_upper_imm;
    assign wb_pc_imm    = ctl.wb_pc_imm;
    assign alu_class    = ctl.cls;
    assign alu_sel      = ctl.known ? sel_raw : '0;

    always_comb begin
        // R1
        unknown_zero_chk: assert (ctl.known || (alu_sel == '0 && alu_class == '0 && !reg_wr
                                  && !opb_imm && !mem_rd && !mem_wr && !is_branch && !is_jal
                                  && !is_jalr && !wb_upper_imm && !wb_pc_imm && !wb_from_mem))
            else $error("unrecognised opcode left a control asserted");
        // R7
        link_wr_chk: assert (!(is_jal || is_jalr) || (reg_wr && alu_sel == SEL_ADD))
            else $error("jump without link write or address add");
    end

endmodule

// File: tb/rvdec_ctrl_decoder_bench.sv
module rvdec_ctrl_decoder_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] opcode = '0;
    logic [2:0] funct3 = '0;
    logic       funct7_b5 = 1'b0;
    logic       reg_wr, opb_imm, wb_from_mem, mem_rd, mem_wr;
    logic       is_branch, is_jal, is_jalr, wb_upper_imm, wb_pc_imm;
    logic [1:0] alu_class;
    logic [3:0] alu_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rvdec_ctrl_decoder u_rvdec_ctrl_decoder (
        .opcode       (opcode),
        .funct3       (funct3),
        .funct7_b5    (funct7_b5),
        .reg_wr       (reg_wr),
        .opb_imm      (opb_imm),
        .wb_from_mem  (wb_from_mem),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .is_branch    (is_branch),
        .is_jal       (is_jal),
        .is_jalr      (is_jalr),
        .wb_upper_imm (wb_upper_imm),
        .wb_pc_imm    (wb_pc_imm),
        .alu_class    (alu_class),
        .alu_sel      (alu_sel)
    );

    // packed order: reg_wr opb_imm wb_from_mem mem_rd mem_wr is_branch is_jal is_jalr
    //               wb_upper_imm wb_pc_imm alu_class[1:0] alu_sel[3:0]
    function automatic logic [15:0] expect_vec(input int op, input int f3, input int b5);
        logic [9:0] f;
        logic [1:0] c;
        logic [3:0] s;
        f = '0; c = 2'd0; s = 4'd2;
        case (op)
            'h33, 'h13: begin
                f = (op == 'h13) ? 10'b1100000000 : 10'b1000000000;
                c = 2'd2;
                case (f3)
                    0: s = (b5 == 1 && op == 'h33) ? 4'd6 : 4'd2;
                    1: s = 4'd4;
                    2: s = 4'd7;
                    3: s = 4'd8;
                    4: s = 4'd3;
                    5: s = (b5 == 1) ? 4'd13 : 4'd5;
                    6: s = 4'd1;
                    default: s = 4'd0;
                endcase
            end
            'h03: f = 10'b1111000000;
            'h23: f = 10'b0100100000;
            'h63: begin
                f = 10'b0000010000;
                c = 2'd1;
                s = (f3 >= 6) ? 4'd8 : (f3 >= 4) ? 4'd7 : 4'd6;
            end
            'h6F: f = 10'b1000001000;
            'h67: f = 10'b1100000100;
            'h37: f = 10'b1000000010;
            'h17: f = 10'b1000000001;
            default: s = 4'd0;
        endcase
        return {f, c, s};
    endfunction

    function automatic string tag_of(input int op, input int f3);
        case (op)
            'h33: return (f3 == 0 || f3 == 5) ? "R2/R10" : "R2/R9";
            'h13: return (f3 == 0 || f3 == 5) ? "R3/R10" : "R3/R9";
            'h03: return "R4/R11";
            'h23: return "R5/R11";
            'h63: return "R6";
            'h6F, 'h67: return "R7";
            'h37, 'h17: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic check_now(input int op, input int f3, input int b5);
        logic [15:0] got;
        logic [15:0] exp;
        got = {reg_wr, opb_imm, wb_from_mem, mem_rd, mem_wr, is_branch, is_jal, is_jalr,
               wb_upper_imm, wb_pc_imm, alu_class, alu_sel};
        exp = expect_vec(op, f3, b5);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s op=%02h f3=%0d b5=%0d actual=%016b expected=%016b",
                     tag_of(op, f3), op, f3, b5, got, exp);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_now(0, 0, 0); // R1 reset-time inputs decode to zero
        for (int op = 0; op < 128; op++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                for (int b5 = 0; b5 < 2; b5++) begin
                    @(negedge clk);
                    opcode    = op[6:0];
                    funct3    = f3[2:0];
                    funct7_b5 = b5[0];
                    #5;
                    check_now(op, f3, b5);
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule